// File: doc/BRIEF.md
# Dual-Page Translation Lookup Unit

This block translates a virtual address into a physical address using a small, fully associative table. Each table entry covers a pair of neighbouring virtual pages, an even page and an odd page, and each page of the pair has its own physical frame base and its own permission flags. The size of the page pair is set per entry by a mask field, so different entries can cover different amounts of memory. The smallest page is 4 KB, which makes the smallest pair 8 KB.

A request gives a virtual address, the current address-space identifier and an access kind: fetch, load or store. The table is searched in the same cycle. One clock edge later the registered response carries a result code, the composed physical address and a write-permission flag. Each kind of failure has its own result code, so the handler that refills the table can tell them apart.

Software or a refill engine loads entries through a write port, one whole entry per cycle, chosen by index. The refill policy and the page walk that feed this port sit outside the block.

Top module: `pairtlb_lookup`

## Requirements
- R1: An entry hits when three conditions hold together: its hardware-invalid flag is 0; its global flag is 1 or its stored address-space ID equals `req_asid`; and its stored virtual page bits equal the request address bits at every position where the effective mask is 0.
- R2: The effective mask is the entry's page-mask field ORed with 0x1FFF. Bits 12..0 of the page-mask field therefore have no effect. A field of 0 gives an 8 KB pair, and a field of 0x0001E000 gives a 128 KB pair.
- R3: The odd page is selected when the request address has a 1 at the bit just above the half mask (effective mask shifted right by one); otherwise the even page is selected. On success the physical address is the selected page's frame base ORed with the request address bits under the half mask.
- R4: If the selected page's valid flag (flags bit 0) is 0, the result code is 2 (invalid). This check comes before every other permission check.
- R5: A fetch (`req_acc`=0) to a page whose execute-inhibit flag (flags bit 2) is 1 gives code 4. A load (`req_acc`=1) to a page whose read-inhibit flag (flags bit 3) is 1 gives code 5. A fetch ignores read-inhibit, and a load ignores execute-inhibit.
- R6: A store (`req_acc`=2) to a valid page whose dirty flag (flags bit 1) is 0 gives code 3 (modified). A fetch or a load that passes its own checks succeeds whatever the dirty flag is.
- R7: On success the code is 0 and `rsp_wr_ok` equals the selected page's dirty flag. On any other code, `rsp_paddr` and `rsp_wr_ok` are 0.
- R8: If no entry hits, the code is 1 (no match).
- R9: If several entries hit, the entry with the lowest index decides the result.
- R10: The response for a request appears after the next rising clock edge. A write to the table in the same cycle as a lookup does not affect that lookup; it affects lookups from the following cycle on.
- R11: Reset sets every entry's hardware-invalid flag to 1 and clears every entry's valid flags. It also sets the response to code 1 with `rsp_paddr` and `rsp_wr_ok` at 0, so every lookup after reset misses until an entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vaddr | input | 32 | Virtual address of the request |
| req_asid | input | 8 | Current address-space identifier |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| rsp_code | output | 3 | Registered result code |
| rsp_paddr | output | 32 | Registered physical address |
| rsp_wr_ok | output | 1 | Registered write-permission flag |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 3 | Entry index to write |
| wr_vpn | input | 32 | Virtual page bits of the new entry |
| wr_pmask | input | 32 | Page-mask field of the new entry |
| wr_asid | input | 8 | Address-space ID of the new entry |
| wr_glob | input | 1 | Global flag: match any address-space ID |
| wr_hw_inv | input | 1 | Hardware-invalid flag |
| wr_pfn_even | input | 32 | Frame base of the even page |
| wr_pfn_odd | input | 32 | Frame base of the odd page |
| wr_fl_even | input | 4 | Even page flags {read-inh, exec-inh, dirty, valid} |
| wr_fl_odd | input | 4 | Odd page flags {read-inh, exec-inh, dirty, valid} |

## Verification
A write to the table and a lookup can fall in the same cycle, and the lookup must then see the table as it was before the write. The bench provokes this on purpose by turning a non-global entry global while it looks up that entry with a foreign address-space ID: the first response must be a miss and the next must be a hit. During random table refills every write also runs at the same time as a random lookup. The reference model computes each expected value before it applies the write, so any early bypass of new contents shows up as a mismatch.

// File: rtl/pairtlb_pkg.sv
package pairtlb_pkg;
  parameter int unsigned VA_W         = 32;
  parameter int unsigned PA_W         = 32;
  parameter int unsigned ASID_W       = 8;
  parameter int unsigned MIN_PG_SHIFT = 12;

  localparam int unsigned PAIR_SHIFT = MIN_PG_SHIFT + 1;
  localparam logic [VA_W-1:0] FIXED_MASK = (VA_W'(1) << PAIR_SHIFT) - VA_W'(1);

  typedef enum logic [2:0] {
    RC_MATCH    = 3'd0,
    RC_NOMATCH  = 3'd1,
    RC_INVALID  = 3'd2,
    RC_MODIFIED = 3'd3,
    RC_EXEC_BLK = 3'd4,
    RC_READ_BLK = 3'd5
  } res_code_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef struct packed {
    logic rd_inh;
    logic ex_inh;
    logic dirty;
    logic valid;
  } pg_flags_t;

  typedef struct packed {
    logic [VA_W-1:0]   vpn;
    logic [VA_W-1:0]   pmask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic              hw_inv;
    logic [PA_W-1:0]   pfn_even;
    logic [PA_W-1:0]   pfn_odd;
    pg_flags_t         fl_even;
    pg_flags_t         fl_odd;
  } tlb_entry_t;

  // Effective mask covering the whole even/odd pair.
  function automatic logic [VA_W-1:0] span_mask(input logic [VA_W-1:0] pmask);
    return pmask | FIXED_MASK;
  endfunction

  // Odd page when the top bit of the mask is set in the address.
  function automatic logic odd_pick(input logic [VA_W-1:0] va, input logic [VA_W-1:0] mask);
    return |(va & mask & ~(mask >> 1));
  endfunction

  // Frame base combined with the in-page offset.
  function automatic logic [PA_W-1:0] frame_addr(input logic [PA_W-1:0] pfn,
                                                input logic [VA_W-1:0] va,
                                                input logic [VA_W-1:0] mask);
    return pfn | PA_W'(va & (mask >> 1));
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import pairtlb_pkg::*;
#(
  parameter  int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_entry_t       wr_data,
  output tlb_entry_t       ent_o [ENTRIES]
);
  tlb_entry_t ents_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents_q[i]        <= '0;
        ents_q[i].hw_inv <= 1'b1;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        ents_q[i] <= wr_data;
      end
    end
    assign ent_o[i] = ents_q[i];
  end
endmodule

// File: rtl/tlb_match_sel.sv
module tlb_match_sel
  import pairtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  tlb_entry_t          ents [ENTRIES],
  input  logic [VA_W-1:0]     va,
  input  logic [ASID_W-1:0]   asid,
  output logic [ENTRIES-1:0]  hit_vec,
  output logic [ENTRIES-1:0]  grant_vec,
  output logic [VA_W-1:0]     sel_pmask,
  output logic [PA_W-1:0]     sel_pfn_even,
  output logic [PA_W-1:0]     sel_pfn_odd,
  output pg_flags_t           sel_fl_even,
  output pg_flags_t           sel_fl_odd
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VA_W-1:0] m;
    logic            id_ok;
    assign m          = span_mask(ents[i].pmask);
    assign id_ok      = ents[i].glob || (ents[i].asid == asid);
    assign hit_vec[i] = id_ok && ((ents[i].vpn & ~m) == (va & ~m)) && !ents[i].hw_inv;
  end

  // Lowest set bit of the hit vector wins.
  assign grant_vec = hit_vec & (~hit_vec + ENTRIES'(1));

  // AND-OR mux driven by the one-hot grant.
  always_comb begin
    sel_pmask    = '0;
    sel_pfn_even = '0;
    sel_pfn_odd  = '0;
    sel_fl_even  = '0;
    sel_fl_odd   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant_vec[i]) begin
        sel_pmask    = sel_pmask    | ents[i].pmask;
        sel_pfn_even = sel_pfn_even | ents[i].pfn_even;
        sel_pfn_odd  = sel_pfn_odd  | ents[i].pfn_odd;
        sel_fl_even  = sel_fl_even  | ents[i].fl_even;
        sel_fl_odd   = sel_fl_odd   | ents[i].fl_odd;
      end
    end
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import pairtlb_pkg::*;
(
  input  logic            hit_any,
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      acc,
  input  logic [VA_W-1:0] pmask,
  input  logic [PA_W-1:0] pfn_even,
  input  logic [PA_W-1:0] pfn_odd,
  input  pg_flags_t       fl_even,
  input  pg_flags_t       fl_odd,
  output logic [2:0]      code,
  output logic [PA_W-1:0] paddr,
  output logic            wr_ok
);
  logic [VA_W-1:0] mask;
  logic            odd;
  pg_flags_t       fl;
  logic [PA_W-1:0] pfn;

  assign mask = span_mask(pmask);
  assign odd  = odd_pick(va, mask);
  assign fl   = odd ? fl_odd  : fl_even;
  assign pfn  = odd ? pfn_odd : pfn_even;

  always_comb begin
    code  = RC_MATCH;
    paddr = '0;
    wr_ok = 1'b0;
    if (!hit_any) begin
      code = RC_NOMATCH;
    end else if (!fl.valid) begin
      code = RC_INVALID;
    end else if (acc == ACC_FETCH && fl.ex_inh) begin
      code = RC_EXEC_BLK;
    end else if (acc == ACC_LOAD && fl.rd_inh) begin
      code = RC_READ_BLK;
    end else if (acc == ACC_STORE && !fl.dirty) begin
      code = RC_MODIFIED;
    end else begin
      paddr = frame_addr(pfn, va, mask);
      wr_ok = fl.dirty;
    end
  end
endmodule

// File: rtl/pairtlb_lookup.sv
module pairtlb_lookup
  import pairtlb_pkg::*;
#(
  parameter  int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_acc,
  output logic [2:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_wr_ok,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic              wr_hw_inv,
  input  logic [PA_W-1:0]   wr_pfn_even,
  input  logic [PA_W-1:0]   wr_pfn_odd,
  input  logic [3:0]        wr_fl_even,
  input  logic [3:0]        wr_fl_odd
);
  tlb_entry_t          wr_data;
  tlb_entry_t          ents [ENTRIES];
  logic [ENTRIES-1:0]  hit_vec;
  logic [ENTRIES-1:0]  grant_vec;
  logic                hit_any;
  logic [VA_W-1:0]     sel_pmask;
  logic [PA_W-1:0]     sel_pfn_even;
  logic [PA_W-1:0]     sel_pfn_odd;
  pg_flags_t           sel_fl_even;
  pg_flags_t           sel_fl_odd;
  logic [2:0]          nxt_code;
  logic [PA_W-1:0]     nxt_paddr;
  logic                nxt_wr_ok;

  always_comb begin
    wr_data          = '0;
    wr_data.vpn      = wr_vpn;
    wr_data.pmask    = wr_pmask;
    wr_data.asid     = wr_asid;
    wr_data.glob     = wr_glob;
    wr_data.hw_inv   = wr_hw_inv;
    wr_data.pfn_even = wr_pfn_even;
    wr_data.pfn_odd  = wr_pfn_odd;
    wr_data.fl_even  = wr_fl_even;
    wr_data.fl_odd   = wr_fl_odd;
  end

  tlb_entry_store #(.ENTRIES(ENTRIES)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ent_o   (ents)
  );

  tlb_match_sel #(.ENTRIES(ENTRIES)) i_match (
    .ents         (ents),
    .va           (req_vaddr),
    .asid         (req_asid),
    .hit_vec      (hit_vec),
    .grant_vec    (grant_vec),
    .sel_pmask    (sel_pmask),
    .sel_pfn_even (sel_pfn_even),
    .sel_pfn_odd  (sel_pfn_odd),
    .sel_fl_even  (sel_fl_even),
    .sel_fl_odd   (sel_fl_odd)
  );

  assign hit_any = |hit_vec;

  tlb_perm_check i_perm (
    .hit_any  (hit_any),
    .va       (req_vaddr),
    .acc      (req_acc),
    .pmask    (sel_pmask),
    .pfn_even (sel_pfn_even),
    .pfn_odd  (sel_pfn_odd),
    .fl_even  (sel_fl_even),
    .fl_odd   (sel_fl_odd),
    .code     (nxt_code),
    .paddr    (nxt_paddr),
    .wr_ok    (nxt_wr_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_code  <= RC_NOMATCH;
      rsp_paddr <= '0;
      rsp_wr_ok <= 1'b0;
    end else begin
      rsp_code  <= nxt_code;
      rsp_paddr <= nxt_paddr;
      rsp_wr_ok <= nxt_wr_ok;
    end
  end
endmodule

// File: rtl/pairtlb_lookup_chk.sv
module pairtlb_lookup_chk
  import pairtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         req_acc,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] grant_vec,
  input logic               hit_any,
  input logic [2:0]         rsp_code,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               rsp_wr_ok
);
  // R8
  nomatch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |=> rsp_code == RC_NOMATCH);

  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> $onehot(grant_vec));

  // R9
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_vec - ENTRIES'(1)) & hit_vec) == '0);

  // R7
  wr_ok_only_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_ok |-> rsp_code == RC_MATCH);

  // R7
  fault_paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_code != RC_MATCH |-> rsp_paddr == '0);

  // R6
  store_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_acc == ACC_STORE && hit_any) |=> (rsp_code != RC_MATCH || rsp_wr_ok));
endmodule

bind pairtlb_lookup pairtlb_lookup_chk #(.ENTRIES(ENTRIES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_acc   (req_acc),
  .hit_vec   (hit_vec),
  .grant_vec (grant_vec),
  .hit_any   (hit_any),
  .rsp_code  (rsp_code),
  .rsp_paddr (rsp_paddr),
  .rsp_wr_ok (rsp_wr_ok)
);

// File: tb/test_pairtlb_lookup.sv
`timescale 1ns/1ps
module test_pairtlb_lookup;
  localparam int ENT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  req_acc = '0;
  logic [2:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic        rsp_wr_ok;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_vpn = '0, wr_pmask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_glob = 1'b0, wr_hw_inv = 1'b0;
  logic [3:0]  wr_fl_even = '0, wr_fl_odd = '0;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pairtlb_lookup #(.ENTRIES(ENT)) i_pairtlb_lookup (.*);

  // reference table
  logic [31:0] m_vpn [ENT];
  logic [31:0] m_pm  [ENT];
  logic [31:0] m_pfe [ENT];
  logic [31:0] m_pfo [ENT];
  logic [7:0]  m_asid[ENT];
  logic        m_g   [ENT];
  logic        m_inv [ENT];
  logic [3:0]  m_fe  [ENT];
  logic [3:0]  m_fo  [ENT];

  function automatic void ref_look(input logic [31:0] va, input logic [7:0] as,
                                   input logic [1:0] acc, output logic [2:0] code,
                                   output logic [31:0] pa, output logic wok);
    int win = -1;
    logic [31:0] pair_sz, page_sz;
    logic [3:0] f;
    logic [31:0] base;
    code = 3'd1; pa = '0; wok = 1'b0;
    // scan from the top so the lowest index is the last to overwrite
    for (int i = ENT - 1; i >= 0; i--) begin
      logic [31:0] sz;
      sz = (m_pm[i] | 32'h0000_1FFF) + 32'd1;     // pair size in bytes (power of two)
      if (!m_inv[i] && (m_g[i] || m_asid[i] == as) &&
          (m_vpn[i] / sz) == (va / sz))
        win = i;
    end
    if (win < 0) return;
    pair_sz = (m_pm[win] | 32'h0000_1FFF) + 32'd1;
    page_sz = pair_sz >> 1;
    if ((va & page_sz) != 0) begin f = m_fo[win]; base = m_pfo[win]; end
    else                     begin f = m_fe[win]; base = m_pfe[win]; end
    if (!f[0])                    code = 3'd2;
    else if (acc == 2'd0 && f[2]) code = 3'd4;
    else if (acc == 2'd1 && f[3]) code = 3'd5;
    else if (acc == 2'd2 && !f[1]) code = 3'd3;
    else begin
      code = 3'd0;
      pa   = base | (va % page_sz);
      wok  = f[1];
    end
  endfunction

  task automatic set_w(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                       input logic [7:0] as, input logic g, input logic inv,
                       input logic [31:0] pfe, input logic [31:0] pfo,
                       input logic [3:0] fe, input logic [3:0] fo);
    wr_idx = 3'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = as; wr_glob = g;
    wr_hw_inv = inv; wr_pfn_even = pfe; wr_pfn_odd = pfo; wr_fl_even = fe; wr_fl_odd = fo;
  endtask

  task automatic commit();
    m_vpn[wr_idx] = wr_vpn; m_pm[wr_idx] = wr_pmask; m_asid[wr_idx] = wr_asid;
    m_g[wr_idx] = wr_glob; m_inv[wr_idx] = wr_hw_inv; m_pfe[wr_idx] = wr_pfn_even;
    m_pfo[wr_idx] = wr_pfn_odd; m_fe[wr_idx] = wr_fl_even; m_fo[wr_idx] = wr_fl_odd;
  endtask

  // One lookup, optionally with a table write in the same cycle.
  task automatic look(input logic [31:0] va, input logic [7:0] as, input logic [1:0] acc,
                      input bit wr, input string tag);
    logic [2:0]  ec;
    logic [31:0] ep;
    logic        ew;
    ref_look(va, as, acc, ec, ep, ew);   // expected from contents before any write
    req_vaddr = va; req_asid = as; req_acc = acc; wr_en = wr;
    @(negedge clk);
    wr_en = 1'b0;
    if (wr) commit();
    checks++;
    if (rsp_code !== ec || rsp_paddr !== ep || rsp_wr_ok !== ew) begin
      errs++;
      $display("FAIL %s va=%h acc=%0d: code=%0d paddr=%h wr_ok=%0b expected code=%0d paddr=%h wr_ok=%0b",
               tag, va, acc, rsp_code, rsp_paddr, rsp_wr_ok, ec, ep, ew);
    end
  endtask

  task automatic write_only();
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    commit();
  endtask

  task automatic expect_code(input logic [2:0] exp, input string tag);
    checks++;
    if (rsp_code !== exp) begin
      errs++;
      $display("FAIL %s: code=%0d expected code=%0d", tag, rsp_code, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < ENT; i++) begin
      m_vpn[i] = '0; m_pm[i] = '0; m_pfe[i] = '0; m_pfo[i] = '0; m_asid[i] = '0;
      m_g[i] = 1'b0; m_inv[i] = 1'b1; m_fe[i] = '0; m_fo[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R11: response state held in reset
    checks++;
    if (rsp_code !== 3'd1 || rsp_paddr !== 32'd0 || rsp_wr_ok !== 1'b0) begin
      errs++;
      $display("FAIL R11 reset: code=%0d paddr=%h wr_ok=%0b expected code=1 paddr=0 wr_ok=0",
               rsp_code, rsp_paddr, rsp_wr_ok);
    end
    rst_n = 1'b1;
    @(negedge clk);
    look(32'h0000_0000, 8'd0, 2'd1, 1'b0, "R11 lookup after reset misses");
    look(32'h0040_0000, 8'd5, 2'd1, 1'b0, "R8 empty table");

    // basic even/odd pair, 8 KB
    set_w(0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h1000_0000, 32'h2000_0000, 4'b0011, 4'b0001);
    write_only();
    look(32'h0040_0123, 8'd5, 2'd1, 1'b0, "R3 R7 even page load");
    expect_code(3'd0, "R1 hit on equal asid");
    look(32'h0040_1ABC, 8'd5, 2'd1, 1'b0, "R3 odd page load");
    look(32'h0040_1ABC, 8'd5, 2'd2, 1'b0, "R6 store to clean page");
    expect_code(3'd3, "R6 modified code");
    look(32'h0040_0010, 8'd5, 2'd2, 1'b0, "R7 store to dirty page");
    look(32'h0040_0010, 8'd6, 2'd1, 1'b0, "R1 R8 foreign asid");
    expect_code(3'd1, "R8 no match code");

    // R10: turn entry 0 global while looking it up with the foreign asid
    set_w(0, 32'h0040_0000, 32'h0, 8'd5, 1'b1, 1'b0, 32'h1000_0000, 32'h2000_0000, 4'b0011, 4'b0001);
    look(32'h0040_0010, 8'd6, 2'd1, 1'b1, "R10 same-cycle write unseen");
    expect_code(3'd1, "R10 old contents used");
    look(32'h0040_0010, 8'd6, 2'd1, 1'b0, "R10 write visible next cycle");
    expect_code(3'd0, "R1 global hit");

    // hardware-invalid entry
    set_w(1, 32'h0080_0000, 32'h0, 8'd5, 1'b1, 1'b1, 32'h1100_0000, 32'h1200_0000, 4'b0011, 4'b0011);
    write_only();
    look(32'h0080_0000, 8'd5, 2'd1, 1'b0, "R1 hw-invalid entry ignored");

    // 128 KB pair, inhibit flags
    set_w(2, 32'h0100_0000, 32'h0001_E000, 8'd7, 1'b0, 1'b0, 32'h3000_0000, 32'h4000_0000, 4'b1001, 4'b0111);
    write_only();
    look(32'h0100_8000, 8'd7, 2'd0, 1'b0, "R5 fetch ignores read-inhibit");
    look(32'h0100_8000, 8'd7, 2'd1, 1'b0, "R5 load read-inhibit");
    expect_code(3'd5, "R5 read-inhibit code");
    look(32'h0101_8000, 8'd7, 2'd0, 1'b0, "R5 fetch execute-inhibit");
    expect_code(3'd4, "R5 execute-inhibit code");
    look(32'h0101_8000, 8'd7, 2'd1, 1'b0, "R5 load ignores execute-inhibit");
    look(32'h0101_8000, 8'd7, 2'd2, 1'b0, "R2 R3 store large odd page");
    look(32'h0102_0000, 8'd7, 2'd1, 1'b0, "R2 outside large pair");

    // page-mask low bits ignored
    set_w(3, 32'h0200_0000, 32'h0000_0FFF, 8'd1, 1'b1, 1'b0, 32'h5000_0000, 32'h6000_0000, 4'b0011, 4'b0011);
    write_only();
    look(32'h0200_1004, 8'd1, 2'd1, 1'b0, "R2 low mask bits ignored odd");
    look(32'h0200_2000, 8'd1, 2'd1, 1'b0, "R2 low mask bits ignored miss");

    // invalid page
    set_w(4, 32'h0300_0000, 32'h0, 8'd1, 1'b1, 1'b0, 32'h5500_0000, 32'h5600_0000, 4'b1110, 4'b0001);
    write_only();
    look(32'h0300_0000, 8'd1, 2'd2, 1'b0, "R4 invalid even page");
    expect_code(3'd2, "R4 invalid code");
    look(32'h0300_1000, 8'd1, 2'd0, 1'b0, "R6 fetch ignores dirty");

    // priority between duplicate entries
    set_w(5, 32'h0400_0000, 32'h0, 8'd1, 1'b1, 1'b0, 32'h7000_0000, 32'h7100_0000, 4'b0011, 4'b0011);
    write_only();
    set_w(6, 32'h0400_0000, 32'h0, 8'd1, 1'b1, 1'b0, 32'h7F00_0000, 32'h7E00_0000, 4'b0001, 4'b0001);
    write_only();
    look(32'h0400_0044, 8'd1, 2'd1, 1'b0, "R9 lowest index wins");
    set_w(5, 32'h0400_0000, 32'h0, 8'd1, 1'b1, 1'b1, 32'h7000_0000, 32'h7100_0000, 4'b0011, 4'b0011);
    write_only();
    look(32'h0400_0044, 8'd1, 2'd1, 1'b0, "R9 next index after invalidation");

    // random phase: refills overlap lookups
    for (int r = 0; r < 6; r++) begin
      for (int e = 0; e < ENT; e++) begin
        int k = $urandom_range(0, 4);
        logic [31:0] pm = ((32'd1 << (2 * k)) - 32'd1) << 13;
        set_w(e, $urandom, pm, 8'($urandom_range(1, 3)), ($urandom % 4) == 0,
              ($urandom % 8) == 0, $urandom, $urandom, 4'($urandom), 4'($urandom));
        look($urandom, 8'($urandom_range(1, 3)), 2'($urandom_range(0, 2)), 1'b1,
             "R10 random lookup during refill");
      end
      for (int n = 0; n < 60; n++) begin
        int j = $urandom_range(0, ENT - 1);
        logic [31:0] sz = m_pm[j] | 32'h0000_1FFF;
        logic [31:0] va = (m_vpn[j] & ~sz) | ($urandom & sz);
        if ($urandom % 10 == 0) va = $urandom;
        look(va, 8'($urandom_range(1, 3)), 2'($urandom_range(0, 2)), 1'b0,
             "R1 R3 R5 R6 R7 random lookup");
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule